// File: doc/BRIEF.md
# Camera Capture Frame Interrupt Controller

This block sequences frame capture on a camera input path and raises the per-frame interrupt that software services. In sensor-input mode it watches the frame-start strobe that arrives with the pixel clock. After a fixed delay, made of a pixel-clock part and a system-clock part, it raises a one-cycle interrupt. This happens before the frame is captured, so the handler runs while the frame is still coming in. The capture-enable and final-interrupt-enable command bits are sampled once per frame, when the frame event fires. When software stops capture with the final interrupt enabled, one more interrupt marks the end of capture and that frame is not captured. With the final interrupt disabled, capture simply stops without an interrupt.

A 2-bit wrapping frame counter, readable at any time, moves forward together with each sensor-mode interrupt. In memory-input mode frames come from memory instead. The frame-start strobe is then ignored, and the interrupt follows each end-of-output-DMA pulse. The counter moves forward when the video-enable bit rises while the scaler capture-enable bit is set. A sticky pending flag records every interrupt and is cleared by a write-one acknowledge.

Top module: `cam_frame_irq_ctrl`

## Requirements
- R1: After reset, irq, last_irq, irq_pend and capture are low and frame_cnt is 0.
- R2: In sensor mode (mem_mode=0), with cap_en high at a frame event, irq rises no earlier than 9 pixel-clock cycles and no later than 9 pixel-clock plus 7 system-clock cycles after the vsync rising edge. The nominal delay is 9 pixel clocks plus 5 system clocks; the exact system-clock part depends on clock phase.
- R3: In sensor mode irq is high for exactly one system-clock cycle per frame event.
- R4: In sensor mode frame_cnt increases by 1 modulo 4 in the same cycle that irq rises (3 wraps to 0), and at no other time.
- R5: If a frame was captured and the next frame event sees cap_en low and last_en high, one irq is raised with last_irq high and capture low. Later frame events with cap_en low raise nothing.
- R6: A frame event with cap_en low and last_en low raises no irq, leaves frame_cnt unchanged and drives capture low.
- R7: In memory mode (mem_mode=1) vsync raises no irq, irq is high for the cycle after each dma_done pulse, and last_irq stays low.
- R8: In memory mode frame_cnt increases by 1 on each 0-to-1 change of vid_en while sc_cap_en is 1. It is unchanged when sc_cap_en is 0, and it is not moved by irq.
- R9: irq_pend goes high with every irq and holds until irq_ack is high in a cycle without a new irq, then reads 0 from the next cycle.
- R10: capture goes high together with an irq from a frame event with cap_en high, and stays high until the next frame event or entry to memory mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low reset, system domain |
| pix_clk | input | 1 | Pixel clock |
| pix_rst_n | input | 1 | Active-low reset, pixel domain |
| vsync | input | 1 | Frame-start strobe, pixel domain, rising edge marks a frame |
| cap_en | input | 1 | Capture-enable command (synchronised) |
| last_en | input | 1 | Final-interrupt-enable command (synchronised) |
| mem_mode | input | 1 | 1 selects memory-input mode |
| vid_en | input | 1 | Video-enable bit that starts memory input |
| sc_cap_en | input | 1 | Scaler capture-enable bit |
| dma_done | input | 1 | One-cycle pulse when output DMA finishes a frame |
| irq_ack | input | 1 | Write-one-to-clear acknowledge of irq_pend |
| irq | output | 1 | One-cycle frame interrupt pulse |
| last_irq | output | 1 | High with irq when it is the end-of-capture interrupt |
| irq_pend | output | 1 | Sticky pending interrupt flag |
| capture | output | 1 | Current frame is being captured |
| frame_cnt | output | 2 | Wrapping frame counter |

## Verification
The hardest case to reach is the final-interrupt path. It needs a captured frame, then a frame event with capture disabled and the final interrupt enabled, then a further such event that must stay silent. The counter has to sit at a known value throughout. The driver reaches it by running a fixed command sequence per frame. It sets the command bits several system cycles before the vsync edge so they cross their synchronisers in time, and it pushes the expected counter, last flag and capture level into the scoreboard. Passing through count 3 first makes the wrap and the final-interrupt increment land on distinct values.

// File: rtl/cfi_pkg.sv
package cfi_pkg;

   typedef enum logic [1:0] {
      FA_SKIP    = 2'd0,
      FA_CAPTURE = 2'd1,
      FA_LAST    = 2'd2
   } frame_act_t;

   // Decision taken once per frame event in sensor mode
   function automatic frame_act_t cfi_decide(input logic cap, input logic fin,
                                             input logic was_cap);
      frame_act_t a;
      if (cap)                a = FA_CAPTURE;
      else if (was_cap && fin) a = FA_LAST;
      else                    a = FA_SKIP;
      return a;
   endfunction

endpackage

// File: rtl/cfi_sync.sv
module cfi_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] ff [STAGES];

   initial begin : p_par
      assert (STAGES >= 2) else $error("cfi_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff[0] <= '0;
      else        ff[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff[i] <= '0;
         else        ff[i] <= ff[i-1];
      end
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/cfi_pix_delay.sv
module cfi_pix_delay #(
   parameter int PIX_DLY = 9
) (
   input  logic pix_clk,
   input  logic pix_rst_n,
   input  logic vsync,
   output logic done_tgl
);
   localparam int CW = $clog2(PIX_DLY + 1);

   logic          vs_q;
   logic          busy;
   logic [CW-1:0] cnt;
   logic          rise;

   initial begin : p_par
      assert (PIX_DLY >= 2) else $error("cfi_pix_delay: PIX_DLY must be at least 2");
   end

   assign rise = vsync & ~vs_q;

   // Edge that sees the rise is pixel cycle 1; toggle flips on cycle PIX_DLY
   always_ff @(posedge pix_clk or negedge pix_rst_n) begin
      if (!pix_rst_n) begin
         vs_q     <= 1'b0;
         busy     <= 1'b0;
         cnt      <= '0;
         done_tgl <= 1'b0;
      end else begin
         vs_q <= vsync;
         if (rise) begin
            busy <= 1'b1;
            cnt  <= CW'(PIX_DLY - 1);
         end else if (busy) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               busy     <= 1'b0;
               done_tgl <= ~done_tgl;
            end
         end
      end
   end
endmodule

// File: rtl/cfi_sys_delay.sv
module cfi_sys_delay #(
   parameter int SYS_DLY     = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic sys_clk,
   input  logic sys_rst_n,
   input  logic tgl_in,
   output logic fire
);
   // Sync stages + chain + the caller's output register make SYS_DLY edges
   localparam int CHAIN = SYS_DLY - SYNC_STAGES - 1;

   logic tgl_s;
   logic tgl_q;
   logic [CHAIN:0] sh;

   initial begin : p_par
      assert (CHAIN >= 0) else $error("cfi_sys_delay: SYS_DLY too small for synchroniser");
   end

   cfi_sync #(.W(1), .STAGES(SYNC_STAGES)) u_tsync (
      .clk  (sys_clk),
      .rst_n(sys_rst_n),
      .d    (tgl_in),
      .q    (tgl_s)
   );

   always_ff @(posedge sys_clk or negedge sys_rst_n) begin
      if (!sys_rst_n) tgl_q <= 1'b0;
      else            tgl_q <= tgl_s;
   end

   assign sh[0] = tgl_s ^ tgl_q;

   for (genvar i = 1; i <= CHAIN; i++) begin : g_chain
      always_ff @(posedge sys_clk or negedge sys_rst_n) begin
         if (!sys_rst_n) sh[i] <= 1'b0;
         else            sh[i] <= sh[i-1];
      end
   end

   assign fire = sh[CHAIN];
endmodule

// File: rtl/cam_frame_irq_ctrl.sv
module cam_frame_irq_ctrl
   import cfi_pkg::*;
#(
   parameter int PIX_DLY     = 9,
   parameter int SYS_DLY     = 5,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 2
) (
   input  logic             sys_clk,
   input  logic             sys_rst_n,
   input  logic             pix_clk,
   input  logic             pix_rst_n,
   input  logic             vsync,
   input  logic             cap_en,
   input  logic             last_en,
   input  logic             mem_mode,
   input  logic             vid_en,
   input  logic             sc_cap_en,
   input  logic             dma_done,
   input  logic             irq_ack,
   output logic             irq,
   output logic             last_irq,
   output logic             irq_pend,
   output logic             capture,
   output logic [CNT_W-1:0] frame_cnt
);
   logic             pix_tgl;
   logic             fire;
   logic [1:0]       cmd_s;
   logic             cap_s, fin_s;
   logic             was_cap;
   logic             vid_q;
   logic             vid_rise;
   frame_act_t       act;

   logic             irq_n, last_n, cap_n, was_n;
   logic [CNT_W-1:0] cnt_n;

   initial begin : p_par
      assert (CNT_W >= 1) else $error("cam_frame_irq_ctrl: CNT_W must be positive");
   end

   cfi_pix_delay #(.PIX_DLY(PIX_DLY)) u_pdly (
      .pix_clk  (pix_clk),
      .pix_rst_n(pix_rst_n),
      .vsync    (vsync),
      .done_tgl (pix_tgl)
   );

   cfi_sys_delay #(.SYS_DLY(SYS_DLY), .SYNC_STAGES(SYNC_STAGES)) u_sdly (
      .sys_clk  (sys_clk),
      .sys_rst_n(sys_rst_n),
      .tgl_in   (pix_tgl),
      .fire     (fire)
   );

   cfi_sync #(.W(2), .STAGES(SYNC_STAGES)) u_csync (
      .clk  (sys_clk),
      .rst_n(sys_rst_n),
      .d    ({cap_en, last_en}),
      .q    (cmd_s)
   );

   assign cap_s    = cmd_s[1];
   assign fin_s    = cmd_s[0];
   assign vid_rise = vid_en & ~vid_q;
   assign act      = cfi_decide(cap_s, fin_s, was_cap);

   always_comb begin
      irq_n  = 1'b0;
      last_n = 1'b0;
      cap_n  = capture;
      was_n  = was_cap;
      cnt_n  = frame_cnt;
      if (mem_mode) begin
         irq_n = dma_done;
         cap_n = 1'b0;
         was_n = 1'b0;
         if (vid_rise && sc_cap_en) cnt_n = frame_cnt + CNT_W'(1);
      end else if (fire) begin
         unique case (act)
            FA_CAPTURE: begin
               irq_n = 1'b1;
               cap_n = 1'b1;
               was_n = 1'b1;
               cnt_n = frame_cnt + CNT_W'(1);
            end
            FA_LAST: begin
               irq_n  = 1'b1;
               last_n = 1'b1;
               cap_n  = 1'b0;
               was_n  = 1'b0;
               cnt_n  = frame_cnt + CNT_W'(1);
            end
            default: begin
               cap_n = 1'b0;
               was_n = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge sys_clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         irq       <= 1'b0;
         last_irq  <= 1'b0;
         irq_pend  <= 1'b0;
         capture   <= 1'b0;
         was_cap   <= 1'b0;
         vid_q     <= 1'b0;
         frame_cnt <= '0;
      end else begin
         irq       <= irq_n;
         last_irq  <= last_n;
         irq_pend  <= irq_n | (irq_pend & ~irq_ack);
         capture   <= cap_n;
         was_cap   <= was_n;
         vid_q     <= vid_en;
         frame_cnt <= cnt_n;
      end
   end
endmodule

// File: rtl/cfi_checker.sv
module cfi_checker #(
   parameter int CNT_W = 2
) (
   input logic             sys_clk,
   input logic             sys_rst_n,
   input logic             mem_mode,
   input logic             irq_ack,
   input logic             irq,
   input logic             last_irq,
   input logic             irq_pend,
   input logic             capture,
   input logic [CNT_W-1:0] frame_cnt
);
   a_r3_irq_single: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      (irq && !mem_mode) |=> (!irq || mem_mode));

   a_r4_cnt_step: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      (irq && !$past(mem_mode)) |-> (frame_cnt == $past(frame_cnt) + CNT_W'(1)));

   a_r6_cnt_hold: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      (!irq && !$past(mem_mode)) |-> $stable(frame_cnt));

   a_r5_last_no_capture: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      last_irq |-> (irq && !capture));

   a_r7_mem_no_last: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      (mem_mode && $past(mem_mode)) |-> !last_irq);

   a_r9_pend_set: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      irq |-> irq_pend);

   a_r9_pend_clear: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      irq_ack |=> (irq || !irq_pend));
endmodule

bind cam_frame_irq_ctrl cfi_checker #(.CNT_W(CNT_W)) u_chk (
   .sys_clk  (sys_clk),
   .sys_rst_n(sys_rst_n),
   .mem_mode (mem_mode),
   .irq_ack  (irq_ack),
   .irq      (irq),
   .last_irq (last_irq),
   .irq_pend (irq_pend),
   .capture  (capture),
   .frame_cnt(frame_cnt)
);

// File: tb/cam_frame_irq_ctrl_tb.sv
`timescale 1ns/1ps
module cam_frame_irq_ctrl_tb;
   localparam time SYS_T = 8ns;
   localparam time PIX_T = 20ns;
   localparam time WIN_LO = 9 * PIX_T;
   localparam time WIN_HI = 9 * PIX_T + 7 * SYS_T;

   logic sys_clk = 0, pix_clk = 0;
   logic sys_rst_n = 0, pix_rst_n = 0;
   logic vsync = 0, cap_en = 0, last_en = 0, mem_mode = 0;
   logic vid_en = 0, sc_cap_en = 0, dma_done = 0, irq_ack = 0;
   logic irq, last_irq, irq_pend, capture;
   logic [1:0] frame_cnt;

   always #(SYS_T/2) sys_clk = ~sys_clk;
   always #(PIX_T/2) pix_clk = ~pix_clk;

   cam_frame_irq_ctrl u_dut (
      .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .pix_clk(pix_clk), .pix_rst_n(pix_rst_n),
      .vsync(vsync), .cap_en(cap_en), .last_en(last_en), .mem_mode(mem_mode),
      .vid_en(vid_en), .sc_cap_en(sc_cap_en), .dma_done(dma_done), .irq_ack(irq_ack),
      .irq(irq), .last_irq(last_irq), .irq_pend(irq_pend), .capture(capture),
      .frame_cnt(frame_cnt)
   );

   typedef struct {
      logic       fin;
      logic       cap;
      logic [1:0] cnt;
      logic       timed;
      time        t0;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0, n_err = 0, irq_seen = 0;
   bit   done = 0;
   logic [1:0] cnt_m = 0;
   bit   was_m = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   // Monitor: pops one scoreboard item per irq rising edge
   bit irq_q = 0, chk_fall = 0;
   always @(negedge sys_clk) begin
      if (sys_rst_n) begin
         if (chk_fall) begin
            chk(!irq, "R3", "irq width", irq, 0);
            chk_fall = 0;
         end
         if (irq && !irq_q) begin
            irq_seen++;
            chk_fall = 1;
            if (q.size() == 0) begin
               chk(0, "R6", "unexpected irq", 1, 0);
            end else begin
               exp_t it;
               it = q.pop_front();
               chk(frame_cnt == it.cnt, "R4", "cnt at irq", frame_cnt, it.cnt);
               chk(last_irq == it.fin, "R5", "last_irq", last_irq, it.fin);
               chk(capture == it.cap, "R10", "capture", capture, it.cap);
               chk(irq_pend, "R9", "pend with irq", irq_pend, 1);
               if (it.timed) begin
                  time d;
                  d = $time - it.t0;
                  chk(d >= WIN_LO && d <= WIN_HI, "R2", "irq delay ns", d, WIN_LO);
               end
            end
         end
         irq_q = irq;
      end
   end

   // Driver: one frame with given commands, expectations pushed before the edge
   task automatic frame(input bit c, input bit l);
      int n0;
      bit exp_irq, exp_cap, exp_fin;
      string tag;
      @(negedge sys_clk);
      cap_en  = c;
      last_en = l;
      repeat (6) @(negedge sys_clk);
      exp_irq = 0; exp_cap = 0; exp_fin = 0;
      if (mem_mode) begin
         tag = "R7";
         was_m = 0;
      end else if (c) begin
         exp_irq = 1; exp_cap = 1; was_m = 1; tag = "R2";
      end else if (was_m && l) begin
         exp_irq = 1; exp_fin = 1; was_m = 0; tag = "R5";
      end else begin
         was_m = 0; tag = "R6";
      end
      if (exp_irq) cnt_m = cnt_m + 2'd1;
      n0 = irq_seen;
      @(negedge pix_clk);
      vsync = 1;
      if (exp_irq) q.push_back('{fin: exp_fin, cap: exp_cap, cnt: cnt_m, timed: 1'b1, t0: $time});
      repeat (4) @(negedge pix_clk);
      vsync = 0;
      repeat (40) @(negedge sys_clk);
      chk(irq_seen - n0 == int'(exp_irq), tag, "irq count per frame", irq_seen - n0, exp_irq);
      chk(frame_cnt == cnt_m, tag, "cnt after frame", frame_cnt, cnt_m);
      chk(capture == exp_cap, "R10", "capture after frame", capture, exp_cap);
   endtask

   initial begin : watchdog
      #1ms;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin : stim
      int n0;
      repeat (4) @(negedge sys_clk);
      sys_rst_n = 1;
      pix_rst_n = 1;
      @(negedge sys_clk);
      chk(!irq, "R1", "irq", irq, 0);
      chk(!last_irq, "R1", "last_irq", last_irq, 0);
      chk(!irq_pend, "R1", "irq_pend", irq_pend, 0);
      chk(!capture, "R1", "capture", capture, 0);
      chk(frame_cnt == 0, "R1", "frame_cnt", frame_cnt, 0);

      // Captured frames through the wrap 3 -> 0
      repeat (5) frame(1, 0);
      // Final interrupt, then silence
      frame(0, 1);
      frame(0, 1);
      // Stop without final interrupt
      frame(1, 0);
      frame(0, 0);
      frame(0, 1);

      // Acknowledge clears pending
      chk(irq_pend, "R9", "pend held", irq_pend, 1);
      @(negedge sys_clk) irq_ack = 1;
      @(negedge sys_clk) irq_ack = 0;
      chk(!irq_pend, "R9", "pend after ack", irq_pend, 0);

      // Memory-input mode
      @(negedge sys_clk) mem_mode = 1;
      frame(1, 1);
      chk(!last_irq, "R7", "no last in mem", last_irq, 0);
      n0 = irq_seen;
      q.push_back('{fin: 1'b0, cap: 1'b0, cnt: cnt_m, timed: 1'b0, t0: 0});
      @(negedge sys_clk) dma_done = 1;
      @(negedge sys_clk) dma_done = 0;
      repeat (4) @(negedge sys_clk);
      chk(irq_seen - n0 == 1, "R7", "irq after dma_done", irq_seen - n0, 1);
      chk(frame_cnt == cnt_m, "R8", "cnt not moved by irq", frame_cnt, cnt_m);

      @(negedge sys_clk) begin sc_cap_en = 1; vid_en = 1; end
      cnt_m = cnt_m + 2'd1;
      @(negedge sys_clk);
      chk(frame_cnt == cnt_m, "R8", "cnt on vid_en rise", frame_cnt, cnt_m);
      vid_en = 0;
      @(negedge sys_clk) sc_cap_en = 0;
      @(negedge sys_clk) vid_en = 1;
      repeat (2) @(negedge sys_clk);
      chk(frame_cnt == cnt_m, "R8", "cnt hold sc_cap_en low", frame_cnt, cnt_m);
      vid_en = 0;
      @(negedge sys_clk) begin sc_cap_en = 1; vid_en = 1; end
      cnt_m = cnt_m + 2'd1;
      @(negedge sys_clk);
      chk(frame_cnt == cnt_m, "R8", "cnt second rise", frame_cnt, cnt_m);

      repeat (10) @(negedge sys_clk);
      chk(q.size() == 0, "R2", "scoreboard drained", q.size(), 0);
      finish_run();
   end
endmodule